// File: doc/BRIEF.md
# Dual-Element Sticky Exception Aggregator

This block collects arithmetic exception pulses from two processing elements, called X and Y, that run either alone (X only) or in lockstep (both elements, SIMD mode). Each element owns a sticky status register that latches every exception it reports and keeps it until software clears it by writing ones. A combined flag vector shows the exceptions seen in the most recent cycle, merged across the active elements.

Software programs a per-kind enable mask. When any enabled kind is latched in the sticky register of an active element, the block emits a single-cycle interrupt request. Leaving the handler clears nothing: software reads both sticky registers to find which element faulted and clears each one separately. Interrupt priority and vectoring sit outside this block.

Top module: `exc_sticky_agg`

## Requirements
- R1: After reset, both sticky registers, the flag vector and the enable mask are zero, and the interrupt request is low.
- R2: An exception pulse on bit i of an active element sets bit i of that element's sticky register at the next clock edge, and the bit stays set across any number of cycles without a clear. Bit order for all four-bit vectors: 0 fixed-point overflow, 1 float overflow, 2 float underflow, 3 float invalid.
- R3: When a pulse and a clear hit the same sticky bit in the same cycle, the bit ends up set.
- R4: A clear is write-one-to-clear: with its strobe high, only the bits written as one are cleared, and only in the addressed element's register; the other element's register is unchanged.
- R5: With SIMD disabled, the Y exception inputs have no effect: the Y sticky register, the flag vector and the interrupt request do not change because of them.
- R6: The interrupt request is high for exactly one cycle on each rising edge of the interrupt condition, and stays low while the condition remains true.
- R7: The interrupt condition is true when some bit is set both in the enable mask and in the X sticky register or (in SIMD mode only) the Y sticky register; a mask write with its strobe high replaces the mask at the next edge, and latched kinds that are masked off never raise a request.
- R8: The flag vector equals, one edge after the pulses, the OR of the X pulses and (in SIMD mode only) the Y pulses.
- R9: In SIMD mode an enabled exception on element Y alone raises the interrupt request, as one on element X does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excX | input | 4 | Per-cycle exception pulses from element X |
| excY | input | 4 | Per-cycle exception pulses from element Y |
| simdEn | input | 1 | High when both elements are active |
| maskWrEn | input | 1 | Strobe to load the enable mask |
| maskWrData | input | 4 | New enable mask value |
| clrXEn | input | 1 | Strobe for a clear of the X sticky register |
| clrXData | input | 4 | Bits of the X sticky register to clear |
| clrYEn | input | 1 | Strobe for a clear of the Y sticky register |
| clrYData | input | 4 | Bits of the Y sticky register to clear |
| stickyX | output | 4 | Sticky exception register of element X |
| stickyY | output | 4 | Sticky exception register of element Y |
| flagVec | output | 4 | Combined exceptions of the last cycle |
| irq | output | 1 | Single-cycle exception interrupt request |

## Verification
Every cycle, the assertions check that sticky bits never fall without a clear, that a pulse wins over a simultaneous clear, that the Y register is frozen outside SIMD mode, that a flag bit always has its sticky bit behind it, and that the request lasts one cycle and only when an enabled kind is latched. Only the bench's scenarios show the exact values: which bits a partial clear leaves, that a clear of one element leaves the other alone, that a mask write alone can raise a request over an already latched kind, and that a second exception under a true condition stays silent.

// File: rtl/exc_agg_pkg.sv
package exc_agg_pkg;
  parameter int EXC_W = 4;

  localparam int EXC_FIX_OVF   = 0;
  localparam int EXC_FLT_OVF   = 1;
  localparam int EXC_FLT_UNF   = 2;
  localparam int EXC_FLT_INVAL = 3;

  typedef logic [EXC_W-1:0] excVec_t;

  typedef struct packed {
    excVec_t setX;
    excVec_t setY;
    excVec_t clrX;
    excVec_t clrY;
    logic    maskLoad;
    excVec_t maskData;
  } strobe_t;
endpackage

// File: rtl/exc_agg_ctrl.sv
module exc_agg_ctrl
  import exc_agg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  excVec_t excX,
  input  excVec_t excY,
  input  logic    simdEn,
  input  logic    maskWrEn,
  input  excVec_t maskWrData,
  input  logic    clrXEn,
  input  excVec_t clrXData,
  input  logic    clrYEn,
  input  excVec_t clrYData,
  input  excVec_t stickyX,
  input  excVec_t stickyY,
  input  excVec_t maskQ,
  output strobe_t strb,
  output logic    irq
);
  localparam excVec_t ZERO_VEC = '0;

  excVec_t activeY;
  logic    condNow;
  logic    condPrev;

  // Element Y only counts while both elements are running
  always_comb begin
    strb.setX     = excX;
    strb.setY     = simdEn ? excY : ZERO_VEC;
    strb.clrX     = clrXEn ? clrXData : ZERO_VEC;
    strb.clrY     = clrYEn ? clrYData : ZERO_VEC;
    strb.maskLoad = maskWrEn;
    strb.maskData = maskWrData;
  end

  always_comb begin
    activeY = simdEn ? stickyY : ZERO_VEC;
    condNow = |(maskQ & (stickyX | activeY));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) condPrev <= 1'b0;
    else       condPrev <= condNow;
  end

  assign irq = condNow & ~condPrev;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R6

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> |(maskQ & (stickyX | stickyY))); // R7
endmodule

// File: rtl/exc_agg_dp.sv
module exc_agg_dp
  import exc_agg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  output excVec_t stickyX,
  output excVec_t stickyY,
  output excVec_t maskQ,
  output excVec_t flagVec
);
  excVec_t stickyQ [2];
  excVec_t setV    [2];
  excVec_t clrV    [2];

  assign setV[0] = strb.setX;
  assign setV[1] = strb.setY;
  assign clrV[0] = strb.clrX;
  assign clrV[1] = strb.clrY;

  for (genvar e = 0; e < 2; e++) begin : g_elem
    // Clear first, then set: a pulse in the same cycle survives
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stickyQ[e] <= '0;
      else       stickyQ[e] <= (stickyQ[e] & ~clrV[e]) | setV[e];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (setV[e] != '0) |=> ((stickyQ[e] & $past(setV[e])) == $past(setV[e]))); // R3

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (clrV[e] == '0) |=> ((stickyQ[e] & $past(stickyQ[e])) == $past(stickyQ[e]))); // R2
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      flagVec <= '0;
    end else begin
      if (strb.maskLoad) maskQ <= strb.maskData;
      flagVec <= strb.setX | strb.setY;
    end
  end

  assign stickyX = stickyQ[0];
  assign stickyY = stickyQ[1];
endmodule

// File: rtl/exc_sticky_agg.sv
module exc_sticky_agg
  import exc_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EXC_W-1:0] excX,
  input  logic [EXC_W-1:0] excY,
  input  logic             simdEn,
  input  logic             maskWrEn,
  input  logic [EXC_W-1:0] maskWrData,
  input  logic             clrXEn,
  input  logic [EXC_W-1:0] clrXData,
  input  logic             clrYEn,
  input  logic [EXC_W-1:0] clrYData,
  output logic [EXC_W-1:0] stickyX,
  output logic [EXC_W-1:0] stickyY,
  output logic [EXC_W-1:0] flagVec,
  output logic             irq
);
  strobe_t strb;
  excVec_t maskQ;

  exc_agg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .excX(excX), .excY(excY), .simdEn(simdEn),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .clrXEn(clrXEn), .clrXData(clrXData), .clrYEn(clrYEn), .clrYData(clrYData),
    .stickyX(stickyX), .stickyY(stickyY), .maskQ(maskQ),
    .strb(strb), .irq(irq)
  );

  exc_agg_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .stickyX(stickyX), .stickyY(stickyY), .maskQ(maskQ), .flagVec(flagVec)
  );

  AST_Y_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!simdEn && !clrYEn) |=> $stable(stickyY)); // R5

  AST_FLAG_BACKED: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec & ~(stickyX | stickyY)) == '0)); // R8
endmodule

// File: tb/tb_exc_sticky_agg.sv
`timescale 1ns/1ps
module tb_exc_sticky_agg;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] excX = '0, excY = '0, maskWrData = '0, clrXData = '0, clrYData = '0;
  logic simdEn = 1'b0, maskWrEn = 1'b0, clrXEn = 1'b0, clrYEn = 1'b0;
  logic [W-1:0] stickyX, stickyY, flagVec;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [W-1:0] sx;
    logic [W-1:0] sy;
    logic [W-1:0] fl;
    logic         iq;
    string        tag;
  } exp_t;

  exp_t expQ[$];
  logic [W-1:0] mX = '0, mY = '0, mMask = '0;

  always #2.5 clk = ~clk;

  exc_sticky_agg dut (
    .clk(clk), .rstN(rstN), .excX(excX), .excY(excY), .simdEn(simdEn),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .clrXEn(clrXEn), .clrXData(clrXData), .clrYEn(clrYEn), .clrYData(clrYData),
    .stickyX(stickyX), .stickyY(stickyY), .flagVec(flagVec), .irq(irq)
  );

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs
  task automatic cyc(input logic [W-1:0] ex, input logic [W-1:0] ey, input logic s,
                     input logic mwe, input logic [W-1:0] md,
                     input logic cxe, input logic [W-1:0] cxd,
                     input logic cye, input logic [W-1:0] cyd, input string tag);
    exp_t it;
    logic [W-1:0] effY, nX, nY, nM;
    logic condOld, condNew;
    @(negedge clk);
    excX = ex; excY = ey; simdEn = s; maskWrEn = mwe; maskWrData = md;
    clrXEn = cxe; clrXData = cxd; clrYEn = cye; clrYData = cyd;
    effY = s ? ey : '0;
    condOld = |(mMask & (mX | (s ? mY : '0)));
    nX = (mX & ~(cxe ? cxd : '0)) | ex;
    nY = (mY & ~(cye ? cyd : '0)) | effY;
    nM = mwe ? md : mMask;
    condNew = |(nM & (nX | (s ? nY : '0)));
    mX = nX; mY = nY; mMask = nM;
    it.sx = nX; it.sy = nY; it.fl = ex | effY;
    it.iq = condNew & ~condOld; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n, input logic s, input string tag);
    for (int i = 0; i < n; i++) cyc('0, '0, s, 0, '0, 0, '0, 0, '0, tag);
  endtask

  // Monitor: compares after each rising edge once outputs have settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && expQ.size() > 0) begin
        exp_t it;
        it = expQ.pop_front();
        check(it.tag, "stickyX", stickyX, it.sx);
        check(it.tag, "stickyY", stickyY, it.sy);
        check(it.tag, "flagVec", flagVec, it.fl);
        check(it.tag, "irq", {3'b0, irq}, {3'b0, it.iq});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "stickyX", stickyX, '0);
    check("R1", "stickyY", stickyY, '0);
    check("R1", "flagVec", flagVec, '0);
    check("R1", "irq", {3'b0, irq}, '0);
    rstN = 1'b1;
    // R1: mask reset to zero, so a latched exception raises nothing
    cyc(4'b0001, '0, 0, 0, '0, 0, '0, 0, '0, "R1");
    cyc('0, '0, 0, 0, '0, 1, 4'b1111, 0, '0, "R1");
    // R7: enable all kinds
    cyc('0, '0, 0, 1, 4'b1111, 0, '0, 0, '0, "R7");
    // R2 / R6: fixed-point overflow on X, SISD
    cyc(4'b0001, '0, 0, 0, '0, 0, '0, 0, '0, "R2");
    idle(4, 0, "R2");
    // R6: further kind while condition true gives no new request
    cyc(4'b0010, '0, 0, 0, '0, 0, '0, 0, '0, "R6");
    idle(2, 0, "R6");
    // R4: partial clear of X
    cyc('0, '0, 0, 0, '0, 1, 4'b0001, 0, '0, "R4");
    // R3: pulse and clear on the same bit
    cyc(4'b0010, '0, 0, 0, '0, 1, 4'b0010, 0, '0, "R3");
    cyc('0, '0, 0, 0, '0, 1, 4'b1111, 0, '0, "R4");
    // R5: Y pulses ignored outside SIMD mode
    cyc('0, 4'b1111, 0, 0, '0, 0, '0, 0, '0, "R5");
    idle(2, 0, "R5");
    // R9: Y alone raises a request in SIMD mode
    cyc('0, 4'b0100, 1, 0, '0, 0, '0, 0, '0, "R9");
    idle(2, 1, "R9");
    // R4: clearing Y leaves X alone
    cyc(4'b1000, '0, 1, 0, '0, 0, '0, 0, '0, "R4");
    cyc('0, '0, 1, 0, '0, 0, '0, 1, 4'b1111, "R4");
    cyc('0, '0, 1, 0, '0, 1, 4'b1111, 0, '0, "R4");
    idle(2, 1, "R6");
    // R8: both elements at once, flags merged
    cyc(4'b0001, 4'b1010, 1, 0, '0, 0, '0, 0, '0, "R8");
    cyc('0, '0, 1, 0, '0, 1, 4'b1111, 1, 4'b1111, "R8");
    // R7: masked-off kind stays silent, then a mask write raises the request
    cyc('0, '0, 1, 1, 4'b1000, 0, '0, 0, '0, "R7");
    cyc(4'b0001, '0, 1, 0, '0, 0, '0, 0, '0, "R7");
    idle(2, 1, "R7");
    cyc('0, '0, 1, 1, 4'b1001, 0, '0, 0, '0, "R7");
    idle(2, 1, "R7");
    // R6: condition falls and rises again
    cyc('0, '0, 1, 0, '0, 1, 4'b0001, 0, '0, "R6");
    cyc(4'b0001, '0, 1, 0, '0, 0, '0, 0, '0, "R6");
    idle(2, 1, "R6");
    @(negedge clk);
    excX = '0; excY = '0; maskWrEn = 0; clrXEn = 0; clrYEn = 0;
    while (expQ.size() > 0) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule